// File: doc/BRIEF.md
# Periodic Interval Timer

The block is a memory-mapped timer that raises a periodic interrupt request. A prescaler divides the system clock by sixteen. Each prescaled tick advances a 20-bit interval count. When the interval count has run through a full programmed period, it returns to zero, and a 12-bit elapsed-period counter advances by one. Software finds out how many periods have passed since it last acknowledged by reading that counter.

Four word registers sit on a simple synchronous bus. That bus has a 2-bit word address, write and read strobes, 32-bit write data and combinational read data:

- Word 0, control: period, run enable and interrupt enable.
- Word 1, status.
- Word 2, acknowledging snapshot. Reading it returns the counters and then clears the status flag and the elapsed-period count.
- Word 3, passive snapshot. Reading it returns the same fields and changes nothing.

The interrupt request is a level sent toward an interrupt controller.

Top module: `pit_timer`

## Requirements
- R1: After reset the control word reads 0x000FFFFF, with period all ones, run enable (bit 24) clear and interrupt enable (bit 25) clear. Status (word 1, bit 0), both snapshots and `irq` all read zero.
- R2: The interval count advances only while run enable is set and the period is nonzero. It advances once every 16 clock cycles, counted from the cycle after the control write.
- R3: The interval count steps from 0 up to period-1 and then returns to 0. On each such completion the elapsed-period count increments by one, modulo 4096.
- R4: Words 2 and 3 return the interval count in bits 19:0 and the elapsed-period count in bits 31:20.
- R5: At a completion with interrupt enable set, the status flag becomes 1. `irq` is high exactly while status and interrupt enable are both set.
- R6: A read of word 2 while run enable is set returns the values from before the read. On the next cycle the status flag and the elapsed-period count are zero. If a completion falls in the same cycle, the elapsed-period count is 1 instead, and status equals interrupt enable.
- R7: A read of word 3, or a read of word 2 while run enable is clear, leaves status and both counters unchanged.
- R8: Clearing run enable zeroes the interval count and the elapsed-period count. The status flag is kept.
- R9: A write to word 0 restarts the prescaler and zeroes the interval count. Writes to words 1 to 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (read side effects occur at the clock edge) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that a bus access carries at most one meaningful strobe. They also assume that a read's side effect is taken at the edge on which `rd_en` is sampled high. The random stimulus drives one operation per cycle, and it issues a write and a read in the same cycle only to an address where the read has no side effect. Periods are kept small in the random phase so that completions, acknowledging reads and restarts collide often. A long directed run with period 1 pushes the elapsed-period count through its wrap.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int PW  = 20,
  parameter int CW  = 12,
  parameter int DIV = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int DWD    = $clog2(DIV);
  localparam int EN_BIT = 24;
  localparam int IE_BIT = 25;

  logic [PW-1:0]  period_q;
  logic           en_q, ie_q, status_q;
  logic [DWD-1:0] pre_q;
  logic [PW-1:0]  cnt_q;
  logic [CW-1:0]  pcnt_q;

  logic run, wr_mode, tick, done, rd_val;

  assign run     = en_q && (period_q != '0);
  assign wr_mode = wr_en && (addr == 2'd0);
  assign tick    = run && (pre_q == DWD'(DIV - 1));
  assign done    = tick && !wr_mode && (cnt_q >= period_q - 1'b1);
  assign rd_val  = rd_en && (addr == 2'd2) && en_q;
  assign irq     = status_q && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
    end else if (wr_mode) begin
      period_q <= wdata[PW-1:0];
      en_q     <= wdata[EN_BIT];
      ie_q     <= wdata[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pre_q <= '0;
    else if (!run || wr_mode || tick) pre_q <= '0;
    else                            pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!en_q || wr_mode)   cnt_q <= '0;
    else if (done)               cnt_q <= '0;
    else if (tick)               cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (!en_q)   pcnt_q <= '0;
    else if (rd_val)  pcnt_q <= CW'(done);
    else if (done)    pcnt_q <= pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              status_q <= 1'b0;
    else if (rd_val)         status_q <= done && ie_q;
    else if (done && ie_q)   status_q <= 1'b1;
  end

  logic [31:0] mode_word, snap_word;
  always_comb begin
    mode_word = '0;
    mode_word[PW-1:0]  = period_q;
    mode_word[EN_BIT]  = en_q;
    mode_word[IE_BIT]  = ie_q;
    snap_word = '0;
    snap_word[PW-1:0]  = cnt_q;
    snap_word[31 -: CW] = pcnt_q;
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = mode_word;
      2'd1:    rdata = {31'd0, status_q};
      default: rdata = snap_word;
    endcase
  end
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int PW = 20,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic          en_q,
  input logic          ie_q,
  input logic          status_q,
  input logic [PW-1:0] period_q,
  input logic [PW-1:0] cnt_q,
  input logic [CW-1:0] pcnt_q,
  input logic          irq
);
  logic wm, run_c;
  assign wm    = wr_en && (addr == 2'd0);
  assign run_c = en_q && (period_q != '0);

  a_r8_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wm) |=> (cnt_q == '0 && pcnt_q == '0));

  a_r5_status_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(ie_q));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd2 && en_q && !ie_q) |=> (!status_q && pcnt_q <= 1));

  a_r7_image_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd3 && !run_c && en_q) |=>
      ($stable(cnt_q) && $stable(pcnt_q) && $stable(status_q)));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  a_r3_elapsed_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt_q == $past(pcnt_q) || pcnt_q == $past(pcnt_q) + 1'b1 || pcnt_q <= 1));

  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q && ie_q));
endmodule

bind pit_timer pit_timer_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .en_q(en_q), .ie_q(ie_q), .status_q(status_q), .period_q(period_q),
  .cnt_q(cnt_q), .pcnt_q(pcnt_q), .irq(irq)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  always #5 clk = ~clk;

  pit_timer u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
                .wdata(wdata), .rdata(rdata), .irq(irq));

  int checks = 0, errors = 0;
  logic [19:0] m_per = 20'hFFFFF;
  logic m_en = 0, m_ie = 0, m_st = 0;
  logic [3:0] m_pre = 0;
  logic [19:0] m_cnt = 0;
  logic [11:0] m_pcnt = 0;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {6'd0, m_ie, m_en, 4'd0, m_per};
      2'd1: return {31'd0, m_st};
      default: return {m_pcnt, m_cnt};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [1:0] a,
                    input logic [31:0] d, input string req);
    logic run, wm, tick, done, rv;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) chk(req, rdata, exp_read(a));
    chk("R5 irq level", {31'd0, irq}, {31'd0, m_st && m_ie});
    run  = m_en && (m_per != 0);
    wm   = w && a == 2'd0;
    tick = run && m_pre == 4'd15;
    done = tick && !wm && (m_cnt >= m_per - 1);
    rv   = r && a == 2'd2 && m_en;
    @(posedge clk);
    m_pre  = (!run || wm || tick) ? 4'd0 : m_pre + 1;
    if (!m_en) m_pcnt = 0;
    else if (rv) m_pcnt = done ? 12'd1 : 12'd0;
    else if (done) m_pcnt = m_pcnt + 1;
    m_cnt  = (!m_en || wm || done) ? 20'd0 : (tick ? m_cnt + 1 : m_cnt);
    if (rv) m_st = done && m_ie;
    else if (done && m_ie) m_st = 1;
    if (wm) begin m_per = d[19:0]; m_en = d[24]; m_ie = d[25]; end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 2'd0, 0, "idle");
  endtask

  function automatic logic [31:0] mk(input logic [19:0] p, input logic en, input logic ie);
    return {6'd0, ie, en, 4'd0, p};
  endfunction

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    op(0, 1, 2'd0, 0, "R1 control reset");
    op(0, 1, 2'd1, 0, "R1 status reset");
    op(0, 1, 2'd2, 0, "R1 value reset");
    op(0, 1, 2'd3, 0, "R1 image reset");
    // R9 writes to other words ignored
    op(1, 0, 2'd1, 32'hFFFF_FFFF, "R9");
    op(1, 0, 2'd3, 32'hFFFF_FFFF, "R9");
    op(0, 1, 2'd1, 0, "R9 status unchanged");
    op(0, 1, 2'd3, 0, "R9 image unchanged");
    // R2 period zero does not run
    op(1, 0, 2'd0, mk(20'd0, 1, 1), "R2");
    idle(40);
    op(0, 1, 2'd3, 0, "R2 period zero holds");
    // R2 R3 R4 R5 running with period 3
    op(1, 0, 2'd0, mk(20'd3, 1, 1), "R2");
    idle(20);
    op(0, 1, 2'd3, 0, "R4 image mid period");
    idle(60);
    op(0, 1, 2'd1, 0, "R5 status set");
    op(0, 1, 2'd3, 0, "R3 elapsed count");
    op(0, 1, 2'd3, 0, "R7 image no effect");
    // R6 acknowledge
    op(0, 1, 2'd2, 0, "R6 ack returns old");
    op(0, 1, 2'd3, 0, "R6 cleared");
    op(0, 1, 2'd1, 0, "R6 status cleared");
    // R8 disable
    idle(70);
    op(1, 0, 2'd0, mk(20'd3, 0, 1), "R8");
    idle(2);
    op(0, 1, 2'd3, 0, "R8 zeroed");
    op(0, 1, 2'd1, 0, "R8 status kept");
    op(0, 1, 2'd2, 0, "R7 disabled value read");
    op(0, 1, 2'd1, 0, "R7 status after disabled read");
    // R3 wrap of elapsed count, period 1, no interrupt
    op(1, 0, 2'd0, mk(20'd1, 1, 0), "R3");
    idle(4096 * 16 + 5);
    op(0, 1, 2'd3, 0, "R3 wrap modulo 4096");
    op(0, 1, 2'd2, 0, "R6 ack after wrap");
    // random mix
    for (int i = 0; i < 20000; i++) begin
      int k = $urandom_range(0, 99);
      logic [1:0] a = 2'($urandom_range(0, 3));
      if (k < 4)
        op(1, 0, 2'd0, mk(20'($urandom_range(0, 4)), 1'($urandom_range(0, 9) != 0),
           1'($urandom_range(0, 1))), "R9 random control");
      else if (k < 6)
        op(1, 0, a == 2'd0 ? 2'd1 : a, $urandom, "R9 random ignored write");
      else if (k < 12)
        op(0, 1, a, 0, "R6 R7 random read");
      else
        op(0, 0, 2'd0, 0, "idle");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule